// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Interlock

This block sits between a PWM controller and the gate drivers of a three-phase bridge. Each phase leg has a high-side and a low-side switch. The controller presents one on request per switch. The block returns one gate enable per switch and never lets both switches of a leg conduct together.

Each leg runs its own owner arbiter, and the first request to arrive takes the leg. While that request stays asserted, the opposite request is held off. When the winning request goes away, the leg spends exactly one idle cycle with both enables off. After that cycle, a request that is still pending is granted.

If both requests reach an idle leg on the same edge, the low side is granted. Request inputs are brought into the clock domain through a configurable synchronizer chain. The block reports no fault and inserts no dead time beyond that single idle cycle. Any real dead time must be produced by the controller.

Top module: `shoot_through_guard`

## Requirements
- R1: In every leg, `hi_en[i]` and `lo_en[i]` are never 1 in the same cycle.
- R2: The first side whose synchronized request reaches an idle leg is enabled. Its enable stays 1 for as long as its synchronized request stays 1, whatever the opposite request does.
- R3: When the owner's synchronized request falls, the owner's enable clears on the next edge. The opposite enable can rise no earlier than one edge after that, so there is one cycle with both enables at 0. It does rise then if its request is still asserted.
- R4: An opposite request that rises and falls entirely while the other side owns the leg never produces a 1 on its enable.
- R5: When both synchronized requests are 1 at an edge and the leg is idle, the low side is enabled and the high side waits.
- R6: While `rst_n` is 0, and on the first edge after it is released, every enable is 0.
- R7: With SYNC_STAGES=2, a request change on an otherwise unopposed leg appears on its enable at the third rising edge after the change. With SYNC_STAGES=0, it appears at the first rising edge.
- R8: The legs are independent. Activity on one leg's requests never changes another leg's enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_req | input | NPH | High-side on request, one bit per leg |
| lo_req | input | NPH | Low-side on request, one bit per leg |
| hi_en | output | NPH | High-side gate enable, one bit per leg |
| lo_en | output | NPH | Low-side gate enable, one bit per leg |

## Verification
The release of a held request and the same-edge tie-break can fall into the same cycle. This happens when the owner drops its request while the opposite side is held, and then reasserts it so that both requests are high during the idle cycle. The bench holds every request pair for two cycles and steps through all 256 four-step sequences per leg, which reaches that collision many times. A cycle-accurate reference derived from R2 to R5 judges each case, expecting the low side to win after the idle cycle.

// File: rtl/shoot_through_guard.sv
module shoot_through_guard #(
  parameter int NPH         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hi_req,
  input  logic [NPH-1:0] lo_req,
  output logic [NPH-1:0] hi_en,
  output logic [NPH-1:0] lo_en
);

  logic [NPH-1:0] hs, ls;
  logic [NPH-1:0] hi_q, lo_q, hi_d, lo_d;

  generate
    if (SYNC_STAGES == 0) begin : g_bypass
      assign hs = hi_req;
      assign ls = lo_req;
    end else begin : g_sync
      logic [NPH-1:0] hp [SYNC_STAGES];
      logic [NPH-1:0] lp [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < SYNC_STAGES; k++) begin
            hp[k] <= '0;
            lp[k] <= '0;
          end
        end else begin
          hp[0] <= hi_req;
          lp[0] <= lo_req;
          for (int k = 1; k < SYNC_STAGES; k++) begin
            hp[k] <= hp[k-1];
            lp[k] <= lp[k-1];
          end
        end
      end
      assign hs = hp[SYNC_STAGES-1];
      assign ls = lp[SYNC_STAGES-1];
    end
  endgenerate

  // owner keeps the leg while its request holds; an idle leg favours low side
  assign lo_d = ls & ~hi_q;
  assign hi_d = hs & ~lo_q & (hi_q | ~ls);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_en = hi_q;
  assign lo_en = lo_q;

endmodule

// File: rtl/shoot_through_guard_chk.sv
module shoot_through_guard_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NPH-1:0] hs,
  input logic [NPH-1:0] ls,
  input logic [NPH-1:0] hi_en,
  input logic [NPH-1:0] lo_en
);

  genvar i;
  generate
    for (i = 0; i < NPH; i++) begin : g_leg
      AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_en[i] && lo_en[i])); // R1
      AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en[i] && hs[i]) |=> hi_en[i]); // R2
      AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en[i] && ls[i]) |=> lo_en[i]); // R2
      AST_HI_BLOCKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en[i] && hs[i]) |=> !lo_en[i]); // R4
      AST_GAP_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_en[i]) |-> !lo_en[i]); // R3
      AST_GAP_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lo_en[i]) |-> !hi_en[i]); // R3
      AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_en[i] && !lo_en[i] && hs[i] && ls[i]) |=> (lo_en[i] && !hi_en[i])); // R5
    end
  endgenerate

endmodule

bind shoot_through_guard shoot_through_guard_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs(hs), .ls(ls), .hi_en(hi_en), .lo_en(lo_en)
);

// File: tb/sim_shoot_through_guard.sv
`timescale 1ns/1ps
module sim_shoot_through_guard;
  localparam int NPH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPH-1:0] hi_req = '0, lo_req = '0;
  logic [NPH-1:0] hi_en, lo_en;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [NPH-1:0] m1h = '0, m1l = '0, m2h = '0, m2l = '0;
  logic [NPH-1:0] eh = '0, el = '0, dropped = '0;
  string tag [NPH];

  always #2.5 clk = ~clk;

  shoot_through_guard #(.NPH(NPH), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .hi_req(hi_req), .lo_req(lo_req),
    .hi_en(hi_en), .lo_en(lo_en)
  );

  task automatic check(input string req, input int leg, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s leg=%0d actual={hi,lo}=%b expected=%b t=%0t", req, leg, act, exp, $time);
    end
  endtask

  // reference: two synchronizer stages, then first-come owner with low-side tie-break
  task automatic tick();
    @(posedge clk);
    for (int p = 0; p < NPH; p++) begin
      logic h, l, nh, nl;
      h = m2h[p]; l = m2l[p];
      if (eh[p]) begin
        nh = h; nl = 1'b0;
        tag[p] = !h ? "R3" : (l ? "R4" : "R2");
      end else if (el[p]) begin
        nl = l; nh = 1'b0;
        tag[p] = !l ? "R3" : (h ? "R4" : "R2");
      end else begin
        nl = l; nh = h & ~l;
        tag[p] = (h && l) ? "R5" : (dropped[p] ? "R3" : "R7");
      end
      dropped[p] = (eh[p] & ~nh) | (el[p] & ~nl);
      eh[p] = nh; el[p] = nl;
    end
    m2h = m1h; m2l = m1l; m1h = hi_req; m1l = lo_req;
    #1;
    for (int p = 0; p < NPH; p++) begin
      check(tag[p], p, {hi_en[p], lo_en[p]}, {eh[p], el[p]});
      check("R1", p, {1'b0, hi_en[p] & lo_en[p]}, 2'b00);
    end
    @(negedge clk);
  endtask

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk);
    for (int p = 0; p < NPH; p++) check("R6", p, {hi_en[p], lo_en[p]}, 2'b00);
    hi_req = '1; lo_req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int p = 0; p < NPH; p++) check("R6", p, {hi_en[p], lo_en[p]}, 2'b00);
    m1h = hi_req; m1l = lo_req;
    @(negedge clk);
    // R7: high request applied before release reaches enables on the third edge
    tick();
    tick();
    for (int p = 0; p < NPH; p++) check("R7", p, {hi_en[p], lo_en[p]}, 2'b10);
    hi_req = '0; tick(); tick(); tick(); tick();

    // near-exhaustive sweep: every 4-step pattern of request pairs, two cycles per step
    for (int s = 0; s < 256; s++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < NPH; p++) begin
          int code;
          code = (s * (2 * p + 1) + p * 37) & 255;
          {hi_req[p], lo_req[p]} = 2'((code >> (2 * k)) & 3);
        end
        tick();
        tick();
      end
    end

    // R4: short low pulse during high ownership never reaches the gate
    hi_req = '0; lo_req = '0; repeat (4) tick();
    hi_req[0] = 1'b1; repeat (4) tick();
    lo_req[0] = 1'b1; tick(); lo_req[0] = 1'b0;
    repeat (4) begin tick(); check("R4", 0, {1'b0, lo_en[0]}, 2'b00); end

    // R8: leg 0 held by high side while legs 1 and 2 churn
    for (int n = 0; n < 40; n++) begin
      hi_req[2:1] = 2'(n); lo_req[2:1] = 2'(n >> 1);
      tick();
      check("R8", 0, {hi_en[0], lo_en[0]}, 2'b10);
    end

    // R6: reset mid-run clears everything
    hi_req = '1; lo_req = '1;
    rst_n = 1'b0; #1;
    for (int p = 0; p < NPH; p++) check("R6", p, {hi_en[p], lo_en[p]}, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule